// File: doc/BRIEF.md
# Freezable Cross-Domain Register Synchronizer

This block carries configuration writes from a fast bus clock domain into a slow low-frequency domain. Each register has a staging copy on the bus side. A plain write strobe with an address and data updates the staging copy and marks that register modified. When no transfer is running, the bus side takes a snapshot of every modified register and starts one transfer. The transfer is a toggle request that crosses a two-flop synchronizer. The slow side loads the snapshot and returns a toggle acknowledge through a second two-flop synchronizer.

A freeze request stops new transfers so that software can prepare several registers. While the block is frozen, writes only collect in the staging copies. When freeze is dropped, every register changed during the freeze moves into the slow domain in one transfer. Entering freeze first waits for any transfer already in flight to finish. A busy bit per register shows that the register is still modified or still being carried across.

Register 0 is the control register: bits [1:0] hold a clock mode and bit 2 holds a counter-reset enable. Register 1 is a counter value. The slow side only loads that counter value when the control mode is one of the internally clocked codes.

Top module: `freeze_sync_regs`

## Requirements
- R1: One bus cycle after a write strobe, busy bit `addr` (bit index equals the register address) is 1.
- R2: Without freeze, a written value appears at `lf_regs[addr*DW +: DW]`. Busy for that register returns to 0 only once the slow-domain copy holds the value.
- R3: While `frozen` is 1, writes do not reach `lf_regs`, and the busy bits of written registers stay 1.
- R4: When freeze is released, all registers modified during the freeze change in the same slow-clock cycle.
- R5: `frozen` does not rise while a transfer is in flight. Once it is 1, the value of that transfer is already present in `lf_regs`.
- R6: Writing the control register (address 0) with the value it already holds still sets its busy bit, and a transfer runs and completes.
- R7: The counter register (address 1) is loaded into the slow domain only when control bits [1:0] are 0 or 1. Under codes 2 or 3 it keeps its previous slow-domain value. The mode that decides is the one in the same transfer if control is part of it, and otherwise the current slow-domain mode.
- R8: A write to a register whose transfer is in flight replaces the staged value. The newest value is delivered afterwards, and busy stays 1 until then.
- R9: After reset, `busy` is 0, `frozen` is 0 and all of `lf_regs` is 0.
- R10: Registers other than the counter register are loaded whatever the control mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Register address of the write |
| wr_data | input | DW | Write data |
| freeze_req | input | 1 | Level request to hold off transfers |
| frozen | output | 1 | Freeze is in effect; no transfer is in flight |
| busy | output | NREG | Per-register modified-or-in-flight flag |
| lf_clk | input | 1 | Slow low-frequency clock |
| lf_rst | input | 1 | Synchronous active-high reset, slow domain |
| lf_regs | output | NREG*DW | Slow-domain register copies, register i at [i*DW +: DW] |

## Verification
The hardest case to reach is a write or a freeze request that lands while a transfer is between its request toggle and the returning acknowledge. The bench issues a write and then, one bus cycle later, either a second write to the same register or a freeze request. Because the bus clock is much faster than the slow clock, the second action lands inside the crossing window. Atomic release is observed by sampling the slow-domain outputs on every slow clock. The bench confirms that the batched registers never show a state where some of them are updated and others are not.

// File: rtl/freeze_sync_pkg.sv
package freeze_sync_pkg;
  // control register field layout (decoded by the slow side)
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 2;
  localparam int RSTEN_BIT = 2;

  typedef enum logic [MODE_W-1:0] {
    CLK_OFF      = 2'd0,
    CLK_INTERNAL = 2'd1,
    CLK_EXT_ONE  = 2'd2,
    CLK_EXT_QUAD = 2'd3
  } clk_mode_e;

  function automatic logic mode_allows_count(input logic [MODE_W-1:0] m);
    return (m == CLK_OFF) || (m == CLK_INTERNAL);
  endfunction
endpackage

// File: rtl/fsr_bit_sync.sv
module fsr_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fsr_stage.sv
module fsr_stage #(
  parameter int NREG = 4,
  parameter int DW   = 16,
  parameter int AW   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [DW-1:0]             wr_data,
  input  logic                      freeze_req,
  input  logic                      ack_sync,
  output logic                      req_tgl,
  output logic [NREG-1:0]           xfer_mask,
  output logic [NREG-1:0][DW-1:0]   xfer_data,
  output logic                      frozen,
  output logic [NREG-1:0]           busy
);
  logic [NREG-1:0][DW-1:0] stg_q;
  logic [NREG-1:0][DW-1:0] xfer_q;
  logic [NREG-1:0]         dirty_q;
  logic [NREG-1:0]         mask_q;
  logic [NREG-1:0]         wr_mask;
  logic                    req_q;
  logic                    frozen_q;
  logic                    inflight;
  logic                    launch;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wr_mask[i] = wr_en && (wr_addr == AW'(i));
    end
  end

  assign inflight = (req_q != ack_sync);
  assign launch   = !inflight && !freeze_req && !frozen_q && (|dirty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q    <= '0;
      xfer_q   <= '0;
      dirty_q  <= '0;
      mask_q   <= '0;
      req_q    <= 1'b0;
      frozen_q <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_mask[i]) stg_q[i] <= wr_data;
      end
      if (launch) begin
        mask_q  <= dirty_q;
        xfer_q  <= stg_q;
        req_q   <= ~req_q;
        dirty_q <= wr_mask;
      end else begin
        dirty_q <= dirty_q | wr_mask;
      end
      frozen_q <= freeze_req && (frozen_q || !inflight);
    end
  end

  assign req_tgl   = req_q;
  assign xfer_mask = mask_q;
  assign xfer_data = xfer_q;
  assign frozen    = frozen_q;
  assign busy      = dirty_q | (inflight ? mask_q : '0);

  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> busy[$past(wr_addr)]); // R1
  AST_NO_LAUNCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    frozen_q |=> $stable(req_q)); // R3
  AST_DIRTY_KEPT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    frozen_q |=> ((dirty_q & $past(dirty_q)) == $past(dirty_q))); // R3
  AST_FREEZE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(frozen_q) |-> !inflight); // R5
  AST_INFLIGHT_HAS_MASK: assert property (@(posedge clk) disable iff (rst)
    inflight |-> (mask_q != '0)); // R2
endmodule

// File: rtl/fsr_lf_side.sv
module fsr_lf_side #(
  parameter int NREG     = 4,
  parameter int DW       = 16,
  parameter int CTRL_IDX = 0,
  parameter int CNT_IDX  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_sync,
  input  logic [NREG-1:0]         xfer_mask,
  input  logic [NREG-1:0][DW-1:0] xfer_data,
  output logic                    ack_tgl,
  output logic [NREG-1:0][DW-1:0] regs
);
  import freeze_sync_pkg::*;

  logic                    seen_q;
  logic                    new_req;
  logic [MODE_W-1:0]       eff_mode;
  logic [NREG-1:0][DW-1:0] regs_q;

  assign new_req  = (req_sync != seen_q);
  assign eff_mode = xfer_mask[CTRL_IDX] ? xfer_data[CTRL_IDX][MODE_LSB +: MODE_W]
                                        : regs_q[CTRL_IDX][MODE_LSB +: MODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      regs_q <= '0;
    end else if (new_req) begin
      seen_q <= req_sync;
      for (int i = 0; i < NREG; i++) begin
        if (xfer_mask[i]) begin
          if (i != CNT_IDX || mode_allows_count(eff_mode)) regs_q[i] <= xfer_data[i];
        end
      end
    end
  end

  assign ack_tgl = seen_q;
  assign regs    = regs_q;

  AST_COUNT_MODE_GATE: assert property (@(posedge clk) disable iff (rst)
    $changed(regs_q[CNT_IDX]) |-> mode_allows_count(regs_q[CTRL_IDX][MODE_LSB +: MODE_W])); // R7
  AST_UPDATE_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    $changed(regs_q) |-> $changed(seen_q)); // R4
endmodule

// File: rtl/freeze_sync_regs.sv
module freeze_sync_regs #(
  parameter int NREG     = 4,
  parameter int DW       = 16,
  parameter int SYNC_FF  = 2,
  parameter int CTRL_IDX = 0,
  parameter int CNT_IDX  = 1,
  localparam int AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              freeze_req,
  output logic              frozen,
  output logic [NREG-1:0]   busy,
  input  logic              lf_clk,
  input  logic              lf_rst,
  output logic [NREG*DW-1:0] lf_regs
);
  logic                    req_tgl, req_sync;
  logic                    ack_tgl, ack_sync;
  logic [NREG-1:0]         xfer_mask;
  logic [NREG-1:0][DW-1:0] xfer_data;
  logic [NREG-1:0][DW-1:0] lf_q;

  fsr_stage #(.NREG(NREG), .DW(DW), .AW(AW)) u_stage (
    .clk(bus_clk), .rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freeze_req(freeze_req), .ack_sync(ack_sync),
    .req_tgl(req_tgl), .xfer_mask(xfer_mask), .xfer_data(xfer_data),
    .frozen(frozen), .busy(busy)
  );

  fsr_bit_sync #(.STAGES(SYNC_FF)) u_req_sync (
    .clk(lf_clk), .rst(lf_rst), .d(req_tgl), .q(req_sync)
  );

  fsr_bit_sync #(.STAGES(SYNC_FF)) u_ack_sync (
    .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_sync)
  );

  fsr_lf_side #(.NREG(NREG), .DW(DW), .CTRL_IDX(CTRL_IDX), .CNT_IDX(CNT_IDX)) u_lf (
    .clk(lf_clk), .rst(lf_rst), .req_sync(req_sync), .xfer_mask(xfer_mask),
    .xfer_data(xfer_data), .ack_tgl(ack_tgl), .regs(lf_q)
  );

  assign lf_regs = lf_q;
endmodule

// File: tb/freeze_sync_regs_test.sv
module freeze_sync_regs_test;
  localparam int NREG = 4;
  localparam int DW   = 16;
  localparam int AW   = 2;

  logic              bus_clk = 0, lf_clk = 0;
  logic              bus_rst = 1, lf_rst = 1;
  logic              wr_en = 0;
  logic [AW-1:0]     wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic              freeze_req = 0;
  logic              frozen;
  logic [NREG-1:0]   busy;
  logic [NREG*DW-1:0] lf_regs;

  int checks = 0, fails = 0;
  logic [DW-1:0] model [NREG];

  always #5  bus_clk = ~bus_clk;
  always #37 lf_clk  = ~lf_clk;

  freeze_sync_regs #(.NREG(NREG), .DW(DW)) uut (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freeze_req(freeze_req), .frozen(frozen), .busy(busy),
    .lf_clk(lf_clk), .lf_rst(lf_rst), .lf_regs(lf_regs)
  );

  function automatic logic [DW-1:0] lfv(input int a);
    return lf_regs[a*DW +: DW];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy !== '0 && n < 3000) begin
      @(negedge bus_clk); n++;
    end
    check(n < 3000, tag, busy, 0);
  endtask

  function automatic bit cnt_ok(input logic [DW-1:0] ctrl);
    return ctrl[1:0] < 2;
  endfunction

  task automatic check_all(input string tag);
    for (int a = 0; a < NREG; a++) check(lfv(a) == model[a], tag, lfv(a), model[a]);
  endtask

  initial begin
    repeat (150000) @(posedge bus_clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < NREG; a++) model[a] = '0;
    repeat (4) @(posedge lf_clk);
    @(negedge bus_clk); bus_rst = 0;
    @(negedge lf_clk);  lf_rst = 0;
    @(negedge bus_clk);
    // R9 reset state
    check(busy == 0, "R9 busy", busy, 0);
    check(frozen == 0, "R9 frozen", frozen, 0);
    check(lf_regs == 0, "R9 lf_regs", lf_regs, 0);

    // R1 / R2 single write
    wr(2, 16'h1234);
    check(busy[2] == 1, "R1 busy after write", busy, 4);
    wait_idle("R2 idle");
    model[2] = 16'h1234;
    check_all("R2 value delivered");

    // R7 / R10 sweep over modes and values
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [DW-1:0] c = DW'(m) | (DW'(k & 1) << 2);
        wr(0, c); wait_idle("R7 ctrl idle"); model[0] = c;
        wr(1, DW'(16'h0100 * (m + 1) + k)); wait_idle("R7 cnt idle");
        if (cnt_ok(c)) model[1] = DW'(16'h0100 * (m + 1) + k);
        wr(2, DW'(16'h2000 + m * 16 + k)); wait_idle("R10 top idle");
        model[2] = DW'(16'h2000 + m * 16 + k);
        wr(3, DW'(16'hA000 ^ (m * 7 + k))); wait_idle("R10 spare idle");
        model[3] = DW'(16'hA000 ^ (m * 7 + k));
        check_all("R7 R10 mode sweep");
      end
    end

    // R6 same-value control write still transfers
    wr(0, model[0]);
    check(busy[0] == 1, "R6 busy on same value", busy, 1);
    wait_idle("R6 transfer completes");
    check_all("R6 unchanged");

    // R8 overwrite while in flight
    wr(3, 16'h5555);
    @(negedge bus_clk);
    wr(3, 16'h6666);
    check(busy[3] == 1, "R8 busy kept", busy, 8);
    wait_idle("R8 idle");
    model[3] = 16'h6666;
    check(lfv(3) == 16'h6666, "R8 newest value", lfv(3), 16'h6666);

    // R5 freeze entry waits for in-flight transfer
    wr(2, 16'h0F0F);
    @(negedge bus_clk);
    freeze_req = 1;
    repeat (3) @(negedge bus_clk);
    check(frozen == 0, "R5 frozen held off", frozen, 0);
    begin
      int n = 0;
      while (!frozen && n < 3000) begin @(negedge bus_clk); n++; end
    end
    model[2] = 16'h0F0F;
    check(frozen == 1, "R5 frozen reached", frozen, 1);
    check(lfv(2) == 16'h0F0F, "R5 value before freeze", lfv(2), 16'h0F0F);

    // R3 writes held while frozen (mode internal so count applies)
    wr(0, 16'h0001); wr(1, 16'hBEEF); wr(2, 16'hCAFE);
    repeat (200) @(negedge bus_clk);
    check_all("R3 lf unchanged while frozen");
    check(busy == 4'b0111, "R3 busy held", busy, 7);

    // R4 atomic release
    freeze_req = 0;
    begin
      bit seen = 0;
      for (int s = 0; s < 40; s++) begin
        int diff;
        @(negedge lf_clk);
        diff = (lfv(0) != model[0]) + (lfv(1) != model[1]) + (lfv(2) != model[2]);
        if (diff != 0) begin
          if (!seen) check(diff == 3, "R4 all change together", diff, 3);
          seen = 1;
        end
      end
      check(seen, "R4 release delivered", seen, 1);
    end
    wait_idle("R4 idle");
    model[0] = 16'h0001; model[1] = 16'hBEEF; model[2] = 16'hCAFE;
    check_all("R4 final values");

    // R7 batched mode change to external blocks the count in same transfer
    freeze_req = 1;
    begin
      int n = 0;
      while (!frozen && n < 3000) begin @(negedge bus_clk); n++; end
    end
    wr(0, 16'h0003); wr(1, 16'h1111);
    freeze_req = 0;
    wait_idle("R7 batch idle");
    model[0] = 16'h0003;
    check_all("R7 count blocked in batch");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule